// File: doc/BRIEF.md
# SPI Eight-Byte Burst Engine

This block is a serial-peripheral master that sits behind two memory-mapped words: a control word and a 64-bit data word. Software loads the data word with the bytes to send, then writes a start command to the control word. The engine runs a full-duplex exchange of all eight bytes. Each bit returned by the peripheral goes into the data-word position of the bit that was just sent. When the exchange is over, the data word holds the eight received bytes. Software therefore polls the busy flag once for every eight bytes rather than once per byte.

To read without sending data, software loads the data word with all ones, so the output line stays high while bytes come in. A single-byte command is also available for short exchanges. The serial clock is the system clock divided by a programmable factor that stays in place across commands. One select line is driven from a control bit that software owns.

Top module: `spi_burst_mmio`

## Requirements
- R1: After synchronous reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 1, and both words read back as zero.
- R2: `bus_addr` 0 selects the control word and 1 selects the data word. In the control word, bit 0 starts an eight-byte burst, bit 1 starts a single-byte transfer, bit 2 is the select enable, bits 15:8 hold the divider DIV and bit 31 is the busy flag. The start bits read as 0. A read presents the selected word on `bus_rdata` one cycle after `bus_addr` is set.
- R3: `spi_sck` idles low (SPI mode 0). Each half period lasts DIV+1 system clocks, so DIV=1 at a 50 MHz system clock gives 12.5 MHz.
- R4: The bits leave in this order: data bits 7:0 first, then bits 15:8, and so on. Each byte goes most significant bit first. A burst makes exactly 64 rising edges, and `spi_mosi` changes only while `spi_sck` is low.
- R5: `spi_miso` is sampled at each rising edge and written into the data-word position of the bit being sent. After a burst, the data word holds the eight received bytes.
- R6: The busy flag rises on the clock edge that accepts a start command. It stays 1 for 128·(DIV+1) system clocks during a burst and then clears with `spi_sck` low.
- R7: With an all-ones data word, `spi_mosi` stays high for the whole burst while the input bytes are still captured.
- R8: A control write accepted while busy is ignored. It does not change DIV, the select line or the transfer in progress.
- R9: A data-word write while busy is ignored. It does not change the bits that are sent or the bits that are received.
- R10: A single-byte command exchanges only bits 7:0. It makes 8 rising edges, keeps busy for 16·(DIV+1) clocks and leaves bits 63:8 unchanged.
- R11: `spi_cs_n` is the inverse of the select-enable bit. It stays asserted between transfers until software clears the bit.
- R12: If both start bits are set in one write, the eight-byte burst is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the selected word |
| bus_addr | input | 1 | Word select: 0 control, 1 data |
| bus_wdata | input | 64 | Write value |
| bus_rdata | output | 64 | Registered read value of the selected word |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | 1 | Active-low peripheral select |

## Verification
A bit counter or position mapping that goes wrong shows up at once: the bytes captured on `spi_mosi` come out in the wrong order, and the data word read back after the burst no longer matches the peripheral's pattern. A divider that is off shows in the measured `spi_sck` period on the first two rising edges. It also changes the exact number of clocks that the polled busy flag stays set. A guard against writes while busy that fails shows within the same burst: the select line drops, the clock period changes or garbage bits appear on the wire.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
  // control word bit positions
  localparam int CTRL_GO_BURST = 0;
  localparam int CTRL_GO_BYTE  = 1;
  localparam int CTRL_SEL      = 2;
  localparam int CTRL_DIV_LSB  = 8;
  localparam int CTRL_BUSY     = 31;

  // word select codes
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'd0,
    XFER_BYTE  = 2'd1,
    XFER_BURST = 2'd2
  } xfer_e;
endpackage

// File: rtl/spi_burst_regs.sv
`timescale 1ns/1ps
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic              wr_sel,
  input  logic              wr_go_burst,
  input  logic              wr_go_byte,
  input  logic              busy,
  input  logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic              cs_n_q,
  output xfer_e             start_kind,
  output logic              data_we
);
  logic              ctrl_we;
  logic [DATA_W-1:0] ctrl_word;

  // writes are accepted only while the engine is idle
  always_comb begin
    ctrl_we = bus_we && (bus_addr == SEL_CTRL) && !busy;
    data_we = bus_we && (bus_addr == SEL_DATA) && !busy;
    start_kind = XFER_NONE;
    if (ctrl_we) begin
      if (wr_go_burst)     start_kind = XFER_BURST;
      else if (wr_go_byte) start_kind = XFER_BYTE;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_DIV_LSB +: DIV_W] = div_q;
    ctrl_word[CTRL_SEL]              = ~cs_n_q;
    ctrl_word[CTRL_BUSY]             = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      cs_n_q    <= 1'b1;
      bus_rdata <= '0;
    end else begin
      if (ctrl_we) begin
        div_q  <= wr_div;
        cs_n_q <= ~wr_sel;
      end
      bus_rdata <= (bus_addr == SEL_DATA) ? data_q : ctrl_word;
    end
  end
endmodule

// File: rtl/spi_burst_clkgen.sv
`timescale 1ns/1ps
module spi_burst_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // one tick per half period of the serial clock
  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_burst_shifter.sv
`timescale 1ns/1ps
module spi_burst_shifter
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  xfer_e             start_kind,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic [DATA_W-1:0] data_q,
  output logic              busy_q,
  output logic              sck_q,
  output logic              mosi_q
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BURST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE  = CNT_W'(7);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_nxt;

  // wire order: byte index ascending, bit index descending inside a byte
  function automatic logic [CNT_W-1:0] wire_pos(input logic [CNT_W-1:0] i);
    return {i[CNT_W-1:3], ~i[2:0]};
  endfunction

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b1;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (data_we) data_q <= wr_data;
      if (start_kind != XFER_NONE) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        cnt_q  <= '0;
        last_q <= (start_kind == XFER_BYTE) ? LAST_BYTE : LAST_BURST;
        mosi_q <= data_q[wire_pos('0)];
      end
    end else if (tick) begin
      if (!sck_q) begin
        sck_q                  <= 1'b1;
        data_q[wire_pos(cnt_q)] <= miso;
      end else begin
        sck_q <= 1'b0;
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_nxt;
          mosi_q <= data_q[wire_pos(cnt_nxt)];
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_mmio.sv
`timescale 1ns/1ps
module spi_burst_mmio
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic              busy_w;
  logic              tick_w;
  logic              data_we_w;
  logic [DIV_W-1:0]  div_w;
  logic [DATA_W-1:0] data_w;
  xfer_e             start_w;

  spi_burst_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wr_div      (bus_wdata[CTRL_DIV_LSB +: DIV_W]),
    .wr_sel      (bus_wdata[CTRL_SEL]),
    .wr_go_burst (bus_wdata[CTRL_GO_BURST]),
    .wr_go_byte  (bus_wdata[CTRL_GO_BYTE]),
    .busy        (busy_w),
    .data_q      (data_w),
    .bus_rdata   (bus_rdata),
    .div_q       (div_w),
    .cs_n_q      (spi_cs_n),
    .start_kind  (start_w),
    .data_we     (data_we_w)
  );

  spi_burst_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_w),
    .div  (div_w),
    .tick (tick_w)
  );

  spi_burst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_w),
    .start_kind (start_w),
    .data_we    (data_we_w),
    .wr_data    (bus_wdata),
    .miso       (spi_miso),
    .data_q     (data_w),
    .busy_q     (busy_w),
    .sck_q      (spi_sck),
    .mosi_q     (spi_mosi)
  );
endmodule

// File: rtl/spi_burst_mmio_chk.sv
`timescale 1ns/1ps
module spi_burst_mmio_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             sck,
  input logic             mosi,
  input logic             cs_n,
  input logic [DIV_W-1:0] div
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck); // R3

  AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi)); // R4

  AST_BUSY_ENDS_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !sck); // R6

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div)); // R8

  AST_SELECT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cs_n)); // R11
endmodule

bind spi_burst_mmio spi_burst_mmio_chk #(.DIV_W(DIV_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (busy_w),
  .sck  (spi_sck),
  .mosi (spi_mosi),
  .cs_n (spi_cs_n),
  .div  (div_w)
);

// File: tb/spi_burst_mmio_tb.sv
`timescale 1ns/1ps
module spi_burst_mmio_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic        bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso;
  logic        spi_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_burst_mmio u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // ---------------- peripheral model ----------------
  logic [63:0] s_tx, s_rx;
  int  sidx, rises;
  bit  low_seen;
  time t_prev, period;

  function automatic int wpos(int i);
    return (i / 8) * 8 + 7 - (i % 8);
  endfunction

  always @(posedge spi_sck) begin
    if (sidx < 64) s_rx[wpos(sidx)] = spi_mosi;
    if (!spi_mosi) low_seen = 1;
    rises++;
    if (t_prev != 0) period = $time - t_prev;
    t_prev = $time;
  end

  always @(negedge spi_sck) begin
    sidx++;
    if (sidx < 64) spi_miso = s_tx[wpos(sidx)];
  end

  task automatic slave_load(input logic [63:0] tx);
    s_tx = tx; s_rx = '0; sidx = 0; rises = 0; low_seen = 0;
    t_prev = 0; period = 0;
    spi_miso = tx[wpos(0)];
  endtask

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctrl(bit go_burst, bit go_byte, bit sel, int div);
    return (64'(div) << 8) | (64'(sel) << 2) | (64'(go_byte) << 1) | 64'(go_burst);
  endfunction

  task automatic bus_wr(input logic a, input logic [63:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [63:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_addr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 1'b0;
    forever begin
      @(negedge clk);
      if (!bus_rdata[31]) break;
      n++;
      if (n > 50000) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [63:0] v;
    check("R1 cs_n", 64'(spi_cs_n), 64'd1);
    check("R1 sck", 64'(spi_sck), 64'd0);
    check("R1 mosi", 64'(spi_mosi), 64'd1);
    bus_rd(1'b0, v); check("R1 ctrl word", v, 64'd0);
    bus_rd(1'b1, v); check("R1 data word", v, 64'd0);
  endtask

  task automatic t_layout();
    logic [63:0] v;
    bus_wr(1'b0, ctrl(0, 0, 1, 5));
    bus_rd(1'b0, v); check("R2 ctrl layout", v, 64'h504);
    check("R11 select asserted", 64'(spi_cs_n), 64'd0);
    bus_wr(1'b0, ctrl(0, 0, 0, 5));
    check("R11 select released", 64'(spi_cs_n), 64'd1);
  endtask

  task automatic run_xfer(input int div, input bit byte_mode,
                          input logic [63:0] tx, input logic [63:0] stx);
    int n;
    logic [63:0] v;
    slave_load(stx);
    bus_wr(1'b1, tx);
    bus_wr(1'b0, ctrl(!byte_mode, byte_mode, 1, div));
    wait_idle(n);
    check(byte_mode ? "R10 busy clocks" : "R6 busy clocks",
          64'(n), 64'((byte_mode ? 16 : 128) * (div + 1)));
    check("R3 sck period", 64'(period), 64'(40 * (div + 1)));
    check(byte_mode ? "R10 edge count" : "R4 edge count",
          64'(rises), byte_mode ? 64'd8 : 64'd64);
    if (byte_mode) check("R10 wire byte", {56'd0, s_rx[7:0]}, {56'd0, tx[7:0]});
    else           check("R4 wire order", s_rx, tx);
    bus_rd(1'b1, v);
    if (byte_mode) check("R10 data word", v, {tx[63:8], stx[7:0]});
    else           check("R5 data word", v, stx);
    check("R11 select held", 64'(spi_cs_n), 64'd0);
  endtask

  task automatic t_all_ones();
    run_xfer(1, 0, '1, 64'h0F1E_2D3C_4B5A_6978);
    check("R7 mosi stayed high", 64'(low_seen), 64'd0);
  endtask

  task automatic t_ignore();
    int n;
    logic [63:0] v;
    slave_load(64'hA5C3_0F96_1248_7EDB);
    bus_wr(1'b1, 64'h1122_3344_5566_7788);
    bus_wr(1'b0, ctrl(1, 0, 1, 3));
    repeat (10) @(negedge clk);
    bus_wr(1'b0, ctrl(1, 0, 0, 0));
    check("R8 select kept", 64'(spi_cs_n), 64'd0);
    bus_wr(1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
    wait_idle(n);
    check("R8 edge count", 64'(rises), 64'd64);
    check("R8 period kept", 64'(period), 64'd160);
    check("R9 wire bits", s_rx, 64'h1122_3344_5566_7788);
    bus_rd(1'b1, v); check("R9 data word", v, 64'hA5C3_0F96_1248_7EDB);
    bus_rd(1'b0, v); check("R8 ctrl kept", v, 64'h304);
  endtask

  task automatic t_both_go();
    int n;
    slave_load(64'h0123_4567_89AB_CDEF);
    bus_wr(1'b1, 64'hFEDC_BA98_7654_3210);
    bus_wr(1'b0, ctrl(1, 1, 1, 0));
    wait_idle(n);
    check("R12 busy clocks", 64'(n), 64'd128);
    check("R12 edge count", 64'(rises), 64'd64);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    s_tx = '0; s_rx = '0; sidx = 64; rises = 0; low_seen = 0;
    t_prev = 0; period = 0; spi_miso = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_layout();
    run_xfer(1, 0, 64'h8001_C3A5_5A3C_F00F, 64'h1357_9BDF_2468_ACE0);
    run_xfer(0, 0, 64'h0102_0408_1020_4080, 64'hFF00_AA55_00FF_55AA);
    run_xfer(2, 1, 64'h7766_5544_3322_11C5, 64'h0000_0000_0000_003A);
    t_all_ones();
    t_ignore();
    t_both_go();
    bus_wr(1'b0, ctrl(0, 0, 0, 0));
    check("R11 select released after bursts", 64'(spi_cs_n), 64'd1);
    finish_run();
  end
endmodule